// File: doc/BRIEF.md
# Dual-Channel Peak Threshold Detector

This block watches two signed sample streams, one carrying line voltage and one carrying load current, side by side. Whenever a valid sample arrives on a channel, its magnitude is formed and compared against that channel's own 16-bit peak level. A sample that lies above the level sets a sticky flag for that channel. The flag holds until the host reads the status register. That read is presented to the block as a one-cycle strobe, and it clears both flags together.

Each flag has its own interrupt enable, and a single interrupt request is the OR of the enabled flags. Only the upper sixteen bits of the 24-bit magnitude are weighed against the level. The low byte matters only when those upper bits equal the level exactly. With the default widths, a level of 0x28F5 places detection at the nominal full-scale current code of 0x28F5C2, which is the least sensitive useful setting.

Top module: `pkd_peak_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both flags and `irq` are low.
- R2: The magnitude of a negative sample is its two's-complement negation. The most negative code 0x800000 saturates to 0x7FFFFF.
- R3: A channel trips only when its magnitude is strictly greater than the 24-bit value {level, 8'h00}. A magnitude equal to that value does not trip.
- R4: A level of 0 makes every nonzero sample trip, and a zero sample does not trip.
- R5: A sample is evaluated only on a cycle where its valid strobe is high. Samples on other cycles have no effect on the flag.
- R6: The voltage channel and the current channel are independent. A hit on one channel never sets the other channel's flag.
- R7: A hit on a valid sample at clock edge N raises the flag after edge N. The flag then stays high on later cycles until a status read.
- R8: A `status_rd` pulse at edge N clears both flags after edge N.
- R9: When a hit and `status_rd` occur at the same edge, the set wins and the flag remains high.
- R10: `irq` is high exactly when some flag is high and that flag's enable is high. The enables never affect whether a flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v_sample | input | 24 | Voltage sample, signed two's complement |
| v_valid | input | 1 | Voltage sample valid strobe |
| i_sample | input | 24 | Current sample, signed two's complement |
| i_valid | input | 1 | Current sample valid strobe |
| v_level | input | 16 | Voltage peak level |
| i_level | input | 16 | Current peak level |
| v_irq_en | input | 1 | Interrupt enable for the voltage flag |
| i_irq_en | input | 1 | Interrupt enable for the current flag |
| status_rd | input | 1 | Status register read strobe, clears both flags |
| v_peak_flag | output | 1 | Sticky voltage peak flag |
| i_peak_flag | output | 1 | Sticky current peak flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The only state in this block is the two flag registers. A wrong flag value therefore shows at `v_peak_flag` or `i_peak_flag` one cycle after the edge that produced it. It reaches `irq` in the same cycle whenever the matching enable is high. Because a flag is sticky, a spurious set stays visible until the next status read. A missed set can stay hidden, so the stimulus places boundary samples exactly at {level, 8'h00}, one LSB above it, and at the saturating negative code. It also places hits on the same edge as a clear. This lets a wrong comparison or a wrong clear priority show up on the very next cycle.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

    // Default widths of one channel
    localparam int SAMPLE_W = 24;
    localparam int LEVEL_W  = 16;
    localparam int NUM_CH   = 2;

    // Channel slots inside the packed per-channel vectors
    localparam int VOLT_IDX = 0;
    localparam int CURR_IDX = 1;

    // Per-channel event produced by the comparison stage
    typedef struct packed {
        logic valid;
        logic over;
    } chan_evt_t;

    // Next state of a sticky flag: a set dominates a clear
    function automatic logic next_flag(input logic cur, input logic set, input logic clr);
        logic nxt;
        if (set)
            nxt = 1'b1;
        else if (clr)
            nxt = 1'b0;
        else
            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/pkd_abs_sat.sv
module pkd_abs_sat #(
    parameter int W = 24
) (
    input  logic [W-1:0] sample,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (sample == MOST_NEG)
            mag = MOST_POS;
        else if (sample[W-1])
            mag = (~sample) + 1'b1;
        else
            mag = sample;
    end
endmodule

// File: rtl/pkd_level_cmp.sv
module pkd_level_cmp #(
    parameter int SAMPLE_W = 24,
    parameter int LEVEL_W  = 16
) (
    input  logic [SAMPLE_W-1:0] mag,
    input  logic [LEVEL_W-1:0]  level,
    input  logic                valid,
    output pkd_pkg::chan_evt_t  evt
);
    localparam int FRAC_W = SAMPLE_W - LEVEL_W;

    logic [LEVEL_W-1:0] mag_hi;
    logic [FRAC_W-1:0]  mag_lo;
    logic               hi_gt;
    logic               hi_eq;

    assign mag_hi = mag[SAMPLE_W-1:FRAC_W];
    assign mag_lo = mag[FRAC_W-1:0];
    assign hi_gt  = mag_hi > level;
    assign hi_eq  = mag_hi == level;

    // Upper bytes decide; low byte only breaks an exact tie on them
    always_comb begin
        evt.valid = valid;
        evt.over  = hi_gt | (hi_eq & (|mag_lo));
    end
endmodule

// File: rtl/pkd_sticky_flag.sv
module pkd_sticky_flag (
    input  logic               clk,
    input  logic               rst,
    input  pkd_pkg::chan_evt_t evt,
    input  logic               clr,
    output logic               flag
);
    logic hit;
    assign hit = evt.valid & evt.over;

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= pkd_pkg::next_flag(flag, hit, clr);
    end
endmodule

// File: rtl/pkd_peak_detect.sv
module pkd_peak_detect #(
    parameter int SAMPLE_W = pkd_pkg::SAMPLE_W,
    parameter int LEVEL_W  = pkd_pkg::LEVEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] v_sample,
    input  logic                v_valid,
    input  logic [SAMPLE_W-1:0] i_sample,
    input  logic                i_valid,
    input  logic [LEVEL_W-1:0]  v_level,
    input  logic [LEVEL_W-1:0]  i_level,
    input  logic                v_irq_en,
    input  logic                i_irq_en,
    input  logic                status_rd,
    output logic                v_peak_flag,
    output logic                i_peak_flag,
    output logic                irq
);
    localparam int NCH = pkd_pkg::NUM_CH;

    logic [NCH-1:0][SAMPLE_W-1:0] smp;
    logic [NCH-1:0][LEVEL_W-1:0]  lvl;
    logic [NCH-1:0]               vld;
    logic [NCH-1:0]               ena;
    logic [NCH-1:0]               flg;

    assign smp[pkd_pkg::VOLT_IDX] = v_sample;
    assign smp[pkd_pkg::CURR_IDX] = i_sample;
    assign lvl[pkd_pkg::VOLT_IDX] = v_level;
    assign lvl[pkd_pkg::CURR_IDX] = i_level;
    assign vld[pkd_pkg::VOLT_IDX] = v_valid;
    assign vld[pkd_pkg::CURR_IDX] = i_valid;
    assign ena[pkd_pkg::VOLT_IDX] = v_irq_en;
    assign ena[pkd_pkg::CURR_IDX] = i_irq_en;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [SAMPLE_W-1:0] mag;
        pkd_pkg::chan_evt_t  evt;

        pkd_abs_sat #(.W(SAMPLE_W)) u_abs (
            .sample (smp[g]),
            .mag    (mag)
        );

        pkd_level_cmp #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) u_cmp (
            .mag    (mag),
            .level  (lvl[g]),
            .valid  (vld[g]),
            .evt    (evt)
        );

        pkd_sticky_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .evt    (evt),
            .clr    (status_rd),
            .flag   (flg[g])
        );
    end

    assign v_peak_flag = flg[pkd_pkg::VOLT_IDX];
    assign i_peak_flag = flg[pkd_pkg::CURR_IDX];
    assign irq         = |(flg & ena);
endmodule

// File: rtl/pkd_peak_detect_chk.sv
module pkd_peak_detect_chk #(
    parameter int SAMPLE_W = pkd_pkg::SAMPLE_W,
    parameter int LEVEL_W  = pkd_pkg::LEVEL_W
) (
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] v_sample,
    input logic                v_valid,
    input logic                i_valid,
    input logic [LEVEL_W-1:0]  v_level,
    input logic                v_irq_en,
    input logic                i_irq_en,
    input logic                status_rd,
    input logic                v_peak_flag,
    input logic                i_peak_flag,
    input logic                irq
);
    localparam logic [SAMPLE_W-1:0] TOP_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [LEVEL_W-1:0]  TOP_LVL = {1'b0, {(LEVEL_W-1){1'b1}}};

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!v_peak_flag && !i_peak_flag && !irq));

    // R7: a raised flag holds until a read
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (v_peak_flag && !status_rd) |=> v_peak_flag);

    assert_no_set_without_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (!v_peak_flag && !v_valid) |=> !v_peak_flag);

    assert_cur_no_set_without_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (!i_peak_flag && !i_valid) |=> !i_peak_flag);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !v_valid && !i_valid) |=> (!v_peak_flag && !i_peak_flag));

    // R9 and R3: a top-code sample under a lower level sets even during a read
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (v_valid && v_sample == TOP_POS && v_level < TOP_LVL) |=> v_peak_flag);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (!v_irq_en && !i_irq_en) |-> !irq);

    assert_irq_follows_flag_R10: assert property (@(posedge clk) disable iff (rst)
        ((v_peak_flag && v_irq_en) || (i_peak_flag && i_irq_en)) |-> irq);
endmodule

bind pkd_peak_detect pkd_peak_detect_chk #(
    .SAMPLE_W (SAMPLE_W),
    .LEVEL_W  (LEVEL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .v_sample    (v_sample),
    .v_valid     (v_valid),
    .i_valid     (i_valid),
    .v_level     (v_level),
    .v_irq_en    (v_irq_en),
    .i_irq_en    (i_irq_en),
    .status_rd   (status_rd),
    .v_peak_flag (v_peak_flag),
    .i_peak_flag (i_peak_flag),
    .irq         (irq)
);

// File: tb/tb_pkd_peak_detect.sv
`timescale 1ns/1ps
module tb_pkd_peak_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] v_sample = '0, i_sample = '0;
    logic        v_valid = 1'b0, i_valid = 1'b0;
    logic [15:0] v_level = '0, i_level = '0;
    logic        v_irq_en = 1'b0, i_irq_en = 1'b0;
    logic        status_rd = 1'b0;
    logic        v_peak_flag, i_peak_flag, irq;

    always #4 clk = ~clk;

    pkd_peak_detect dut (
        .clk(clk), .rst(rst),
        .v_sample(v_sample), .v_valid(v_valid),
        .i_sample(i_sample), .i_valid(i_valid),
        .v_level(v_level), .i_level(i_level),
        .v_irq_en(v_irq_en), .i_irq_en(i_irq_en),
        .status_rd(status_rd),
        .v_peak_flag(v_peak_flag), .i_peak_flag(i_peak_flag), .irq(irq)
    );

    typedef struct {
        bit    v;
        bit    i;
        bit    q;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mv = 0, mi = 0;
    bit    done = 0;

    // Reference magnitude and threshold taken from R2, R3 and R4
    function automatic bit ref_trip(input logic [23:0] s, input logic [15:0] lvl);
        longint m;
        longint thr;
        m = longint'($signed(s));
        if (m < 0) m = -m;
        if (m > 64'h7FFFFF) m = 64'h7FFFFF;
        thr = longint'(lvl) * 256;
        return m > thr;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input logic [23:0] vs, input bit vv,
                        input logic [23:0] is, input bit iv,
                        input bit rd, input string tag);
        exp_t e;
        @(negedge clk);
        v_sample = vs; v_valid = vv; i_sample = is; i_valid = iv; status_rd = rd;
        if (vv && ref_trip(vs, v_level)) mv = 1; else if (rd) mv = 0;
        if (iv && ref_trip(is, i_level)) mi = 1; else if (rd) mi = 0;
        e.v = mv; e.i = mi;
        e.q = (mv && v_irq_en) || (mi && i_irq_en);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic clear_all();
        step(24'h0, 0, 24'h0, 0, 1, "R8");
    endtask

    // Monitor: compare after each edge that has a pending expectation
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (v_peak_flag !== e.v || i_peak_flag !== e.i || irq !== e.q) begin
                n_fail++;
                $display("FAIL %s: got v=%b i=%b irq=%b expected v=%b i=%b irq=%b",
                         e.tag, v_peak_flag, i_peak_flag, irq, e.v, e.i, e.q);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_checks++;  // R1 during reset
        if (v_peak_flag !== 1'b0 || i_peak_flag !== 1'b0 || irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got v=%b i=%b irq=%b expected 0 0 0", v_peak_flag, i_peak_flag, irq);
        end
        @(negedge clk);
        rst = 1'b0;
        step(24'h0, 0, 24'h0, 0, 0, "R1");

        // R3: equality does not trip, one LSB above does
        v_level = 16'h1000;
        step(24'h100000, 1, 24'h0, 0, 0, "R3");
        step(24'h100001, 1, 24'h0, 0, 0, "R3");
        step(24'h0, 0, 24'h0, 0, 0, "R7");
        step(24'h0, 0, 24'h0, 0, 0, "R7");
        clear_all();

        // R2: negative magnitudes and saturation
        step(24'hF00000, 1, 24'h0, 0, 0, "R2");   // -0x100000 equals threshold
        step(24'hEFFFFF, 1, 24'h0, 0, 0, "R2");   // -0x100001 trips
        clear_all();
        v_level = 16'h7FFF;
        step(24'h7FFF00, 1, 24'h0, 0, 0, "R3");
        step(24'h800000, 1, 24'h0, 0, 0, "R2");   // saturates to 0x7FFFFF
        clear_all();

        // R3: full-scale current level
        i_level = 16'h28F5;
        step(24'h0, 0, 24'h28F500, 1, 0, "R3");
        step(24'h0, 0, 24'hD70AFF, 1, 0, "R3");   // -0x28F501
        clear_all();

        // R4: zero level
        v_level = 16'h0000;
        step(24'h000000, 1, 24'h0, 0, 0, "R4");
        step(24'h000001, 1, 24'h0, 0, 0, "R4");
        clear_all();
        step(24'hFFFFFF, 1, 24'h0, 0, 0, "R4");
        clear_all();

        // R5: invalid samples ignored
        v_level = 16'h0100; i_level = 16'h0100;
        step(24'h7FFFFF, 0, 24'h7FFFFF, 0, 0, "R5");
        step(24'h800000, 0, 24'h800000, 0, 0, "R5");

        // R6: channels independent
        step(24'h0, 0, 24'h200000, 1, 0, "R6");
        step(24'h300000, 1, 24'h0, 0, 0, "R6");
        clear_all();
        step(24'h0, 0, 24'h0, 0, 0, "R8");

        // R9: set during read wins; other flag clears
        step(24'h200000, 1, 24'h0, 0, 0, "R9");
        step(24'h0, 0, 24'h200000, 1, 1, "R9");
        step(24'h200000, 1, 24'h0, 0, 1, "R9");
        clear_all();

        // R10: enables gate only the request
        step(24'h200000, 1, 24'h0, 0, 0, "R10");
        @(negedge clk); v_irq_en = 1'b1;
        step(24'h0, 0, 24'h0, 0, 0, "R10");
        @(negedge clk); v_irq_en = 1'b0; i_irq_en = 1'b1;
        step(24'h0, 0, 24'h0, 0, 0, "R10");
        step(24'h0, 0, 24'h200000, 1, 0, "R10");
        clear_all();

        step(24'h0, 0, 24'h0, 0, 0, "R8");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule